// File: doc/BRIEF.md
# Write-Once Protected Configuration Register

This block holds one configuration byte that drives downstream clock logic. Two independent guards protect it. The byte can be changed only once between resets. Each change must also be armed by a write to a separate command location on the bus access just before it. A sticky error flag records every write attempt that was not armed. A write that was armed correctly but arrives after the one allowed change is dropped quietly and does not set the flag.

Software uses a short sequence. It writes any value to the command location, then writes the new byte to the configuration location on the very next bus access. After that it reads the status location to confirm the result. The error flag is cleared in one of two ways: by a write to the status location with bit 0 low, or by a one-cycle pulse on the dedicated clear input. The synchronous reset stands for both power-on clear and the external reset.

Top module: `cfg_lock_reg`

## Requirements
- R1: After a reset, at most one write changes `cfg_out`. Every later configuration write leaves it unchanged until the next reset.
- R2: A write to the configuration address (default 0) updates `cfg_out` at the next clock edge only if an unlock is pending. An unlock is pending after a write of any value to the command address (default 1), and idle cycles with no access do not cancel it.
- R3: A write to the configuration address with no pending unlock sets `prot_err` to 1 at the next edge.
- R4: An armed configuration write that arrives after the one allowed write is dropped, and `prot_err` stays 0.
- R5: `prot_err` stays set until one of two events: a write to the status address (default 2) with `bus_wdata[0]` = 0, or a high `err_clr`. A status write with bit 0 = 1 leaves it set.
- R6: Any bus read, or any write to an address other than the command address, between the command write and the configuration write cancels the unlock.
- R7: While `rst` is high, `cfg_out` becomes 0x00, `prot_err` becomes 0 and the written-once flag is cleared. A new reset allows one fresh write.
- R8: A configuration write with no pending unlock does not change `cfg_out`.
- R9: When a violation and a clear request occur in the same cycle, the violation wins and `prot_err` ends at 1.
- R10: `bus_rdata` is combinational on `bus_addr`. It shows the stored byte at the configuration address and {zeros, written flag in bit 1, `prot_err` in bit 0} at the status address. It reads 0 at every other address, including the command address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or external) |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe (counts as an access) |
| bus_wdata | input | DATA_W | Write data |
| err_clr | input | 1 | Clear request for the error flag |
| bus_rdata | output | DATA_W | Read data for the addressed location |
| cfg_out | output | DATA_W | Stored configuration byte to clock logic |
| prot_err | output | 1 | Sticky unlock-sequence violation flag |

## Verification
Two functions of this block can fall in the same cycle: a sequence violation that sets the error flag, and a clear request that drops it. The bench provokes this with an unarmed configuration write issued while `err_clr` is high and the flag is already set. It expects the flag to read 1 afterwards. A plain clear pulse on the next access must then bring it back to 0. The bench also runs an armed write after the one allowed write in the same run. It checks that this quiet discard never raises the flag, so the two kinds of rejection are told apart.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CFG  = 2'd1,
        TGT_CMD  = 2'd2,
        TGT_STAT = 2'd3
    } tgt_e;

    typedef struct packed {
        logic cfg_wr;
        logic cmd_wr;
        logic stat_wr;
        logic any_acc;
    } bus_evt_t;

    function automatic bus_evt_t classify(input logic wr, input logic rd, input tgt_e tgt);
        bus_evt_t e;
        e.cfg_wr  = wr && (tgt == TGT_CFG);
        e.cmd_wr  = wr && (tgt == TGT_CMD);
        e.stat_wr = wr && (tgt == TGT_STAT);
        e.any_acc = wr || rd;
        return e;
    endfunction

endpackage

// File: rtl/unlock_tracker.sv
module unlock_tracker
    import cfg_lock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     pending
);
    logic pending_nxt;

    always_comb begin
        pending_nxt = pending;
        if (evt.cmd_wr)
            pending_nxt = 1'b1;
        else if (evt.any_acc)
            pending_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else
            pending <= pending_nxt;
    end
endmodule

// File: rtl/once_store.sv
module once_store #(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              try_wr,
    input  logic              unlocked,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              written
);
    logic accept;

    assign accept = try_wr && unlocked && !written;

    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= RESET_VAL;
            written <= 1'b0;
        end else if (accept) begin
            value   <= wdata;
            written <= 1'b1;
        end
    end
endmodule

// File: rtl/err_flag.sv
module err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
    import cfg_lock_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CFG_ADDR  = 0,
    parameter int CMD_ADDR  = 1,
    parameter int STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              err_clr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cfg_out,
    output logic              prot_err
);
    localparam int          STAT_PAD = DATA_W - 2;
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    tgt_e     tgt;
    bus_evt_t evt;
    logic     unlock_pend;
    logic     cfg_written;
    logic     violation;
    logic     clear_req;

    always_comb begin
        if (bus_addr == A_CFG)
            tgt = TGT_CFG;
        else if (bus_addr == A_CMD)
            tgt = TGT_CMD;
        else if (bus_addr == A_STAT)
            tgt = TGT_STAT;
        else
            tgt = TGT_NONE;
    end

    assign evt       = classify(bus_wr, bus_rd, tgt);
    assign violation = evt.cfg_wr && !unlock_pend;
    assign clear_req = err_clr || (evt.stat_wr && !bus_wdata[0]);

    unlock_tracker u_unlock (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .pending (unlock_pend)
    );

    once_store #(
        .DATA_W    (DATA_W),
        .RESET_VAL ('0)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .try_wr   (evt.cfg_wr),
        .unlocked (unlock_pend),
        .wdata    (bus_wdata),
        .value    (cfg_out),
        .written  (cfg_written)
    );

    err_flag u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (violation),
        .clr  (clear_req),
        .flag (prot_err)
    );

    always_comb begin
        unique case (tgt)
            TGT_CFG:  bus_rdata = cfg_out;
            TGT_STAT: bus_rdata = {{STAT_PAD{1'b0}}, cfg_written, prot_err};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_lock_reg_chk.sv
module cfg_lock_reg_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CFG_ADDR  = 0,
    parameter int CMD_ADDR  = 1,
    parameter int STAT_ADDR = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              err_clr,
    input logic [DATA_W-1:0] cfg_out,
    input logic              prot_err,
    input logic              pending,
    input logic              written
);
    logic cfg_hit, cmd_hit, stat_hit;
    assign cfg_hit  = bus_wr && (bus_addr == ADDR_W'(CFG_ADDR));
    assign cmd_hit  = bus_wr && (bus_addr == ADDR_W'(CMD_ADDR));
    assign stat_hit = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));

    p_once_r1: assert property (@(posedge clk) disable iff (rst)
        (written && $past(written)) |-> (cfg_out == $past(cfg_out)));

    p_unlock_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_out != $past(cfg_out)) |-> $past(pending && cfg_hit));

    p_viol_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_hit && !pending) |=> prot_err);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_hit && pending && written && !prot_err) |=> !prot_err);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (prot_err && !err_clr && !(stat_hit && !bus_wdata[0])) |=> prot_err);

    p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (pending && !cmd_hit && (bus_wr || bus_rd)) |=> !pending);

    p_reset_r7: assert property (@(posedge clk)
        $past(rst) |-> (cfg_out == '0 && !prot_err && !written));

    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_hit && !pending) |=> $stable(cfg_out));
endmodule

bind cfg_lock_reg cfg_lock_reg_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CFG_ADDR  (CFG_ADDR),
    .CMD_ADDR  (CMD_ADDR),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .err_clr   (err_clr),
    .cfg_out   (cfg_out),
    .prot_err  (prot_err),
    .pending   (unlock_pend),
    .written   (cfg_written)
);

// File: tb/sim_cfg_lock_reg.sv
`timescale 1ns/1ps
module sim_cfg_lock_reg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] A_CFG  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = A_STAT;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              err_clr = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] cfg_out;
    logic              prot_err;
    logic [ADDR_W-1:0] idle_addr = A_STAT;

    always #2 clk = ~clk;

    cfg_lock_reg u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .err_clr   (err_clr),
        .bus_rdata (bus_rdata),
        .cfg_out   (cfg_out),
        .prot_err  (prot_err)
    );

    typedef struct {
        logic [DATA_W-1:0] cfg;
        logic              err;
        logic [DATA_W-1:0] rdata;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic expect_state(input logic [7:0] c, input logic e, input logic [7:0] rd, input string tag);
        exp_t it;
        it.cfg = c; it.err = e; it.rdata = rd; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_chk++;
                if (cfg_out !== it.cfg || prot_err !== it.err || bus_rdata !== it.rdata) begin
                    n_fail++;
                    $display("FAIL %s: cfg=%02h err=%0b rdata=%02h expected cfg=%02h err=%0b rdata=%02h",
                             it.tag, cfg_out, prot_err, bus_rdata, it.cfg, it.err, it.rdata);
                end
            end
        end
    end

    task automatic bus_op(input logic wr, input logic rd, input logic [ADDR_W-1:0] a,
                          input logic [7:0] d, input logic clr);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; err_clr = clr;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = idle_addr; bus_wdata = '0; err_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_state(8'h00, 1'b0, 8'h00, "R7 reset state");

        bus_op(1, 0, A_CFG, 8'h77, 0);
        expect_state(8'h00, 1'b1, 8'h01, "R3 R8 unarmed write");

        bus_op(1, 0, A_STAT, 8'h01, 0);
        expect_state(8'h00, 1'b1, 8'h01, "R5 status write of 1 keeps flag");
        bus_op(1, 0, A_STAT, 8'h00, 0);
        expect_state(8'h00, 1'b0, 8'h00, "R5 status write of 0 clears");

        bus_op(1, 0, A_CMD, 8'h00, 0);
        bus_op(0, 1, A_STAT, 8'h00, 0);
        bus_op(1, 0, A_CFG, 8'h11, 0);
        expect_state(8'h00, 1'b1, 8'h01, "R6 read cancels unlock");
        bus_op(0, 0, A_STAT, 8'h00, 1);
        expect_state(8'h00, 1'b0, 8'h00, "R5 clear input");

        bus_op(1, 0, A_CMD, 8'h00, 0);
        bus_op(1, 0, A_STAT, 8'h01, 0);
        bus_op(1, 0, A_CFG, 8'h22, 0);
        expect_state(8'h00, 1'b1, 8'h01, "R6 other write cancels unlock");
        bus_op(0, 0, A_STAT, 8'h00, 1);
        expect_state(8'h00, 1'b0, 8'h00, "R5 clear input again");

        bus_op(1, 0, A_CMD, 8'h5A, 0);
        bus_op(1, 0, A_CFG, 8'hA5, 0);
        expect_state(8'hA5, 1'b0, 8'h02, "R2 armed write stored");

        idle_addr = A_CFG;
        bus_op(0, 0, A_CFG, 8'h00, 0);
        expect_state(8'hA5, 1'b0, 8'hA5, "R10 read config address");
        idle_addr = A_CMD;
        bus_op(0, 0, A_CMD, 8'h00, 0);
        expect_state(8'hA5, 1'b0, 8'h00, "R10 read command address");
        idle_addr = A_STAT;

        bus_op(1, 0, A_CMD, 8'h00, 0);
        bus_op(1, 0, A_CFG, 8'h3C, 0);
        expect_state(8'hA5, 1'b0, 8'h02, "R4 R1 second armed write dropped quietly");

        bus_op(1, 0, A_CFG, 8'hFF, 0);
        expect_state(8'hA5, 1'b1, 8'h03, "R1 R3 unarmed write after lock");

        bus_op(1, 0, A_CFG, 8'h00, 1);
        expect_state(8'hA5, 1'b1, 8'h03, "R9 violation beats clear");
        bus_op(0, 0, A_STAT, 8'h00, 1);
        expect_state(8'hA5, 1'b0, 8'h02, "R9 clear afterwards");

        do_reset();
        expect_state(8'h00, 1'b0, 8'h00, "R7 reset mid run");
        bus_op(1, 0, A_CMD, 8'h00, 0);
        bus_op(1, 0, A_CFG, 8'h5A, 0);
        expect_state(8'h5A, 1'b0, 8'h02, "R7 R1 fresh write after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule